// File: doc/BRIEF.md
# Even/Odd Interleaved DRAM Bank Controller

This controller sits between a 16-bit processor bus and a DRAM module that has four row strobes and four column strobes. The module is wired as two independent 16-bit halves. Bit 0 of the word address picks the half, so words at even addresses live in one half and words at odd addresses live in the other. Each half has its own sequencer, its own multiplexed address bus and its own write enable. While one half sits out its row precharge, an access to the other half can start at once. A run of consecutive words therefore alternates halves and never waits for precharge.

Every access is a full cycle: the row strobe falls, then the column strobe falls after a set delay, and then the row precharges. No page mode is used. The most significant address bit selects which of the two row strobes of a half is driven. This picks one of the four banks. The address bits between the half bit and the bank bit are split into a column field and a row field. The column strobes of a half are gated per byte lane by the byte enables. The ready output tells the processor when the column data is valid. A free-running counter provides a refresh-request pulse as a stub for a later refresh scheduler.

Top module: `dram_interleave_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, all `ras_n`, `cas_n` and `we_n` lines are high, `cpu_ready` is low, and `refresh_due` is low.
- R2: `cpu_addr[0]` selects the half. An even address drives only `ras_n[0]` or `ras_n[2]`, and an odd address drives only `ras_n[1]` or `ras_n[3]`.
- R3: The top address bit `cpu_addr[AW-1]` is the bank bit. Line `ras_n[2*bank+half]` is the one driven low, and at most one row strobe per half is low at any time.
- R4: The address bus of a half carries the row field `cpu_addr[COL_W+ROW_W:COL_W+1]` while its row strobe is low and no column strobe is active. It carries the zero-extended column field `cpu_addr[COL_W:1]` while its column phase is active.
- R5: A request accepted in cycle c drives the row strobe low in cycles c+1 onward. The column phase runs for T_CAS cycles starting in cycle c+T_RCD+1. `cpu_ready` is high in the last column cycle, which is c+T_RCD+T_CAS (cycle c+4 with the defaults).
- R6: After an access, a half holds its row strobes high for T_RP cycles before it starts another access. Two back-to-back accesses to the same half have their ready pulses T_RCD+T_CAS+T_RP+1 cycles apart (9 with the defaults).
- R7: An access to the opposite half does not wait for the precharge of the half just used. Its ready pulse comes T_RCD+T_CAS+1 cycles after the previous one (5 with the defaults).
- R8: The `we_n[h]` line of a half is low during the row and column phases of a write and high during a read.
- R9: `cas_n[2*h+lane]` is lane `lane` of half `h`. On a write, only the lanes whose `cpu_be` bit is set go low. On a read, both lanes go low (READ_ALL_LANES=1).
- R10: Every access drives a fresh falling edge of a row strobe, and a column strobe is active only while a row strobe of the same half is low.
- R11: `refresh_due` pulses high for one cycle once every REF_INTERVAL cycles. The first pulse comes in the REF_INTERVAL-th cycle after reset.
- R12: `cpu_ready` is high for exactly one cycle per accepted access. A new access is accepted only after the ready pulse of the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access strobe, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_be | input | 2 | Byte-lane enables |
| cpu_addr | input | AW | Word address {bank, row, column, half} |
| cpu_ready | output | 1 | Column data valid, access complete |
| ras_n | output | 4 | Row strobes, index 2*bank+half |
| cas_n | output | 4 | Column strobes, index 2*half+lane |
| we_n | output | 2 | Write enable per half |
| dram_addr_even | output | MW | Multiplexed row/column address, even half |
| dram_addr_odd | output | MW | Multiplexed row/column address, odd half |
| refresh_due | output | 1 | Periodic refresh-request pulse |

## Verification
A sequencer stuck in a phase, or a counter loaded with the wrong value, shows up within one cycle of the affected access. It appears as a misplaced strobe edge, a wrong address phase or an early or late ready, and the per-clock model comparison catches it. A wrong steering bit drives the wrong row strobe in the cycle after acceptance. A half that skips precharge shows up at the ready-to-ready spacing of same-half sequences. A wrong lane gate appears on `cas_n` during the column phase of the write.

// File: rtl/dram_il_pkg.sv
package dram_il_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ROW  = 2'd1,
      PH_COL  = 2'd2,
      PH_PRE  = 2'd3
   } phase_e;
endpackage

// File: rtl/dram_il_addr_split.sv
module dram_il_addr_split #(
   parameter int ROW_W = 10,
   parameter int COL_W = 9,
   localparam int AW = ROW_W + COL_W + 2
) (
   input  logic [AW-1:0]    addr,
   output logic             half,
   output logic             bank,
   output logic [ROW_W-1:0] row,
   output logic [COL_W-1:0] col
);
   assign half = addr[0];
   assign col  = addr[COL_W:1];
   assign row  = addr[COL_W+ROW_W:COL_W+1];
   assign bank = addr[AW-1];
endmodule

// File: rtl/dram_il_half_seq.sv
module dram_il_half_seq
   import dram_il_pkg::*;
#(
   parameter int ROW_W = 10,
   parameter int COL_W = 9,
   parameter int T_RCD = 2,
   parameter int T_CAS = 2,
   parameter int T_RP  = 4,
   parameter bit READ_ALL_LANES = 1'b1,
   localparam int MW   = (ROW_W > COL_W) ? ROW_W : COL_W,
   localparam int TMAX = (T_RCD > T_CAS) ? ((T_RCD > T_RP) ? T_RCD : T_RP)
                                         : ((T_CAS > T_RP) ? T_CAS : T_RP),
   localparam int CW   = $clog2(TMAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             bank_in,
   input  logic [ROW_W-1:0] row_in,
   input  logic [COL_W-1:0] col_in,
   input  logic             we_in,
   input  logic [1:0]       be_in,
   output logic             idle,
   output logic             done,
   output logic [1:0]       ras_n,
   output logic [1:0]       cas_n,
   output logic             we_n,
   output logic [MW-1:0]    addr
);
   phase_e           phase;
   logic [CW-1:0]    cnt;
   logic             bank_q;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;
   logic             we_q;
   logic [1:0]       be_q;
   logic [1:0]       lane_en;
   logic             ras_act;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt    <= '0;
         bank_q <= 1'b0;
         row_q  <= '0;
         col_q  <= '0;
         we_q   <= 1'b0;
         be_q   <= 2'b00;
      end else begin
         unique case (phase)
            PH_IDLE: if (start) begin
               phase  <= PH_ROW;
               cnt    <= CW'(T_RCD - 1);
               bank_q <= bank_in;
               row_q  <= row_in;
               col_q  <= col_in;
               we_q   <= we_in;
               be_q   <= be_in;
            end
            PH_ROW: if (cnt == '0) begin
               phase <= PH_COL;
               cnt   <= CW'(T_CAS - 1);
            end else cnt <= cnt - 1'b1;
            PH_COL: if (cnt == '0) begin
               phase <= PH_PRE;
               cnt   <= CW'(T_RP - 1);
            end else cnt <= cnt - 1'b1;
            PH_PRE: if (cnt == '0) phase <= PH_IDLE;
                    else cnt <= cnt - 1'b1;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   generate
      if (READ_ALL_LANES) begin : g_read_full
         assign lane_en = we_q ? be_q : 2'b11;
      end else begin : g_read_gated
         assign lane_en = be_q;
      end
   endgenerate

   assign ras_act  = (phase == PH_ROW) || (phase == PH_COL);
   assign idle     = (phase == PH_IDLE);
   assign done     = (phase == PH_COL) && (cnt == '0);
   assign ras_n[0] = !(ras_act && !bank_q);
   assign ras_n[1] = !(ras_act && bank_q);
   assign cas_n    = ~((phase == PH_COL) ? lane_en : 2'b00);
   assign we_n     = !(ras_act && we_q);
   assign addr     = (phase == PH_COL) ? MW'(col_q) : MW'(row_q);

   // precharge window tracker for checking
   logic [CW-1:0] hi_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n) hi_cnt <= CW'(T_RP);
      else if (ras_n != 2'b11) hi_cnt <= '0;
      else if (hi_cnt < CW'(T_RP)) hi_cnt <= hi_cnt + 1'b1;
   end

   AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      ((ras_n != 2'b11) && ($past(ras_n) == 2'b11)) |-> ($past(hi_cnt) >= CW'(T_RP))); // R6
   AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_n != 2'b11) |-> (ras_n != 2'b11)); // R10
   AST_ONE_ROW_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~ras_n) <= 1); // R3
   AST_WRITE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_n != 2'b11) |-> (we_n == !we_q)); // R8
endmodule

// File: rtl/dram_il_refresh_tick.sv
module dram_il_refresh_tick #(
   parameter int INTERVAL = 64,
   localparam int RW = $clog2(INTERVAL)
) (
   input  logic clk,
   input  logic rst_n,
   output logic due
);
   logic [RW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else if (cnt == RW'(INTERVAL - 1)) cnt <= '0;
      else cnt <= cnt + 1'b1;
   end

   assign due = rst_n && (cnt == RW'(INTERVAL - 1));
endmodule

// File: rtl/dram_interleave_ctrl.sv
module dram_interleave_ctrl #(
   parameter int ROW_W        = 10,
   parameter int COL_W        = 9,
   parameter int T_RCD        = 2,
   parameter int T_CAS        = 2,
   parameter int T_RP         = 4,
   parameter int REF_INTERVAL = 64,
   parameter bit READ_ALL_LANES = 1'b1,
   localparam int AW = ROW_W + COL_W + 2,
   localparam int MW = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [1:0]    cpu_be,
   input  logic [AW-1:0] cpu_addr,
   output logic          cpu_ready,
   output logic [3:0]    ras_n,
   output logic [3:0]    cas_n,
   output logic [1:0]    we_n,
   output logic [MW-1:0] dram_addr_even,
   output logic [MW-1:0] dram_addr_odd,
   output logic          refresh_due
);
   if (T_RCD < 1) begin : g_bad_rcd
      $error("T_RCD must be at least 1");
   end
   if (T_CAS < 1) begin : g_bad_cas
      $error("T_CAS must be at least 1");
   end
   if (T_RP < 1) begin : g_bad_rp
      $error("T_RP must be at least 1");
   end
   if (REF_INTERVAL < 2) begin : g_bad_ref
      $error("REF_INTERVAL must be at least 2");
   end

   logic             sel_half, sel_bank;
   logic [ROW_W-1:0] sel_row;
   logic [COL_W-1:0] sel_col;
   logic             issued, issued_half, go;
   logic [1:0]       h_idle, h_done;
   logic [1:0]       h_ras [2];
   logic [1:0]       h_cas [2];
   logic [MW-1:0]    h_addr [2];

   dram_il_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
      .addr(cpu_addr), .half(sel_half), .bank(sel_bank),
      .row(sel_row), .col(sel_col)
   );

   assign go = cpu_req && !issued && h_idle[sel_half];

   for (genvar g = 0; g < 2; g++) begin : g_half
      dram_il_half_seq #(
         .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_CAS(T_CAS),
         .T_RP(T_RP), .READ_ALL_LANES(READ_ALL_LANES)
      ) u_seq (
         .clk(clk), .rst_n(rst_n),
         .start(go && (sel_half == 1'(g))),
         .bank_in(sel_bank), .row_in(sel_row), .col_in(sel_col),
         .we_in(cpu_we), .be_in(cpu_be),
         .idle(h_idle[g]), .done(h_done[g]),
         .ras_n(h_ras[g]), .cas_n(h_cas[g]), .we_n(we_n[g]),
         .addr(h_addr[g])
      );
      assign ras_n[g]       = h_ras[g][0];
      assign ras_n[2+g]     = h_ras[g][1];
      assign cas_n[2*g+1:2*g] = h_cas[g];
   end

   assign dram_addr_even = h_addr[0];
   assign dram_addr_odd  = h_addr[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issued      <= 1'b0;
         issued_half <= 1'b0;
      end else if (go) begin
         issued      <= 1'b1;
         issued_half <= sel_half;
      end else if (cpu_ready) begin
         issued      <= 1'b0;
      end
   end

   assign cpu_ready = issued && h_done[issued_half];

   dram_il_refresh_tick #(.INTERVAL(REF_INTERVAL)) u_ref (
      .clk(clk), .rst_n(rst_n), .due(refresh_due)
   );

   AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready); // R12
   AST_EVEN_STEER: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !cpu_addr[0]) |=> ((ras_n[0] & ras_n[2]) == 1'b0)); // R2
   AST_ODD_STEER: assert property (@(posedge clk) disable iff (!rst_n)
      (go && cpu_addr[0]) |=> ((ras_n[1] & ras_n[3]) == 1'b0)); // R2
   AST_READY_WITH_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && !cpu_we) |-> (cas_n != 4'hF)); // R5
   AST_REFRESH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_due |=> !refresh_due); // R11
endmodule

// File: tb/dram_interleave_ctrl_test.sv
module dram_interleave_ctrl_test;
   localparam int ROW_W = 10, COL_W = 9, T_RCD = 2, T_CAS = 2, T_RP = 4;
   localparam int REF_INTERVAL = 64;
   localparam int AW = ROW_W + COL_W + 2;
   localparam int MW = (ROW_W > COL_W) ? ROW_W : COL_W;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cpu_req = 1'b0, cpu_we = 1'b0;
   logic [1:0] cpu_be = 2'b00;
   logic [AW-1:0] cpu_addr = '0;
   logic cpu_ready, refresh_due;
   logic [3:0] ras_n, cas_n;
   logic [1:0] we_n;
   logic [MW-1:0] dram_addr_even, dram_addr_odd;

   int checks = 0, failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   dram_interleave_ctrl #(
      .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_CAS(T_CAS),
      .T_RP(T_RP), .REF_INTERVAL(REF_INTERVAL), .READ_ALL_LANES(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_be(cpu_be), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .dram_addr_even(dram_addr_even), .dram_addr_odd(dram_addr_odd),
      .refresh_due(refresh_due)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference: phase 0 idle, 1 row, 2 column, 3 precharge
   int m_ph[2], m_cnt[2], m_bank[2], m_row[2], m_col[2], m_we[2], m_be[2];
   int m_issued = 0, m_ih = 0, m_ref = 0, accepted = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int h = 0; h < 2; h++) begin
            m_ph[h] = 0; m_cnt[h] = 0; m_bank[h] = 0; m_row[h] = 0;
            m_col[h] = 0; m_we[h] = 0; m_be[h] = 0;
         end
         m_issued = 0; m_ih = 0; m_ref = 0;
      end else begin
         int h_sel;
         bit rdy, take;
         h_sel = int'(cpu_addr[0]);
         rdy  = (m_issued != 0) && m_ph[m_ih] == 2 && m_cnt[m_ih] == 0;
         take = cpu_req && m_issued == 0 && m_ph[h_sel] == 0;
         for (int h = 0; h < 2; h++) begin
            case (m_ph[h])
               0: if (take && h == h_sel) begin
                     m_ph[h] = 1; m_cnt[h] = T_RCD - 1;
                     m_bank[h] = int'(cpu_addr[AW-1]);
                     m_row[h]  = int'(cpu_addr[COL_W+ROW_W:COL_W+1]);
                     m_col[h]  = int'(cpu_addr[COL_W:1]);
                     m_we[h] = int'(cpu_we); m_be[h] = int'(cpu_be);
                  end
               1: if (m_cnt[h] == 0) begin m_ph[h] = 2; m_cnt[h] = T_CAS - 1; end
                  else m_cnt[h]--;
               2: if (m_cnt[h] == 0) begin m_ph[h] = 3; m_cnt[h] = T_RP - 1; end
                  else m_cnt[h]--;
               default: if (m_cnt[h] == 0) m_ph[h] = 0; else m_cnt[h]--;
            endcase
         end
         if (take) begin m_issued = 1; m_ih = h_sel; accepted++; end
         else if (rdy) m_issued = 0;
         m_ref = (m_ref == REF_INTERVAL - 1) ? 0 : m_ref + 1;
      end
   end

   // per-clock comparison at the falling edge
   int ras_falls = 0;
   logic [3:0] ras_prev = 4'hF;
   always @(negedge clk) begin
      if (rst_n) begin
         logic [3:0] e_ras, e_cas;
         logic [1:0] e_we;
         int e_addr[2];
         bit e_rdy;
         e_ras = 4'hF; e_cas = 4'hF; e_we = 2'b11;
         for (int h = 0; h < 2; h++) begin
            int lanes;
            bit act;
            act = (m_ph[h] == 1 || m_ph[h] == 2);
            if (act) e_ras[2*m_bank[h]+h] = 1'b0;
            if (act && m_we[h] != 0) e_we[h] = 1'b0;
            lanes = (m_we[h] != 0) ? m_be[h] : 3;
            if (m_ph[h] == 2) begin
               if (lanes[0]) e_cas[2*h] = 1'b0;
               if (lanes[1]) e_cas[2*h+1] = 1'b0;
            end
            e_addr[h] = (m_ph[h] == 2) ? m_col[h] : m_row[h];
         end
         e_rdy = (m_issued != 0) && m_ph[m_ih] == 2 && m_cnt[m_ih] == 0;
         check(ras_n == e_ras, "R2/R3 row strobes", int'(ras_n), int'(e_ras));
         check(cas_n == e_cas, "R9 column strobes", int'(cas_n), int'(e_cas));
         check(we_n == e_we, "R8 write enables", int'(we_n), int'(e_we));
         check(int'(dram_addr_even) == e_addr[0], "R4 even address", int'(dram_addr_even), e_addr[0]);
         check(int'(dram_addr_odd) == e_addr[1], "R4 odd address", int'(dram_addr_odd), e_addr[1]);
         check(cpu_ready == e_rdy, "R5 ready timing", int'(cpu_ready), int'(e_rdy));
         check(refresh_due == (m_ref == REF_INTERVAL - 1), "R11 refresh pulse",
               int'(refresh_due), int'(m_ref == REF_INTERVAL - 1));
         for (int i = 0; i < 4; i++) if (ras_prev[i] && !ras_n[i]) ras_falls++;
         ras_prev = ras_n;
      end
   end

   function automatic logic [AW-1:0] mk(input int bank, input int row, input int col, input int half);
      return {1'(bank), ROW_W'(row), COL_W'(col), 1'(half)};
   endfunction

   // present a request at the current falling edge; return edges until ready
   task automatic access(input logic [AW-1:0] a, input bit w, input logic [1:0] be, output int n);
      cpu_req = 1'b1; cpu_addr = a; cpu_we = w; cpu_be = be;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!cpu_ready);
   endtask

   initial begin
      int n, ready_cycles;
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      check(ras_n == 4'hF && cas_n == 4'hF && we_n == 2'b11 && !cpu_ready && !refresh_due,
            "R1 reset state", int'({ras_n, cas_n}), 'hFF);
      rst_n = 1'b1;
      @(negedge clk);
      check(ras_n == 4'hF && cas_n == 4'hF && !cpu_ready, "R1 after reset", int'({ras_n, cas_n}), 'hFF);

      access(mk(0, 5, 3, 0), 1'b0, 2'b11, n);
      check(n == T_RCD + T_CAS, "R5 latency from idle", n, T_RCD + T_CAS);
      access(mk(0, 7, 9, 1), 1'b1, 2'b01, n);
      check(n == T_RCD + T_CAS + 1, "R7 opposite half spacing", n, T_RCD + T_CAS + 1);
      access(mk(0, 8, 4, 1), 1'b0, 2'b11, n);
      check(n == T_RCD + T_CAS + T_RP + 1, "R6 same half spacing", n, T_RCD + T_CAS + T_RP + 1);
      access(mk(1, 300, 17, 0), 1'b1, 2'b10, n);
      check(n == T_RCD + T_CAS + 1, "R3 bank one opposite half", n, T_RCD + T_CAS + 1);
      cpu_req = 1'b0;
      @(negedge clk);
      check(cpu_ready == 1'b0, "R12 single ready", int'(cpu_ready), 0);
      repeat (6) @(negedge clk);

      lfsr = 16'hACE1;
      for (int i = 0; i < 60; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         access(mk(int'(lfsr[15]), int'(lfsr[11:2]), int'(lfsr[14:6]), int'(lfsr[0] ^ lfsr[7])),
                lfsr[3], (lfsr[5:4] == 2'b00) ? 2'b11 : lfsr[5:4], n);
         if (lfsr[9] && lfsr[8]) begin
            cpu_req = 1'b0;
            repeat (int'(lfsr[2:1])) @(negedge clk);
         end
      end
      cpu_req = 1'b0;

      // R12: with the request held, ready pulses stay single-cycle
      ready_cycles = 0;
      cpu_req = 1'b1; cpu_addr = mk(0, 1, 1, 0); cpu_we = 1'b0; cpu_be = 2'b11;
      repeat (T_RCD + T_CAS) @(negedge clk);
      if (cpu_ready) ready_cycles++;
      cpu_req = 1'b0;
      @(negedge clk);
      if (cpu_ready) ready_cycles++;
      check(ready_cycles == 1, "R12 ready width", ready_cycles, 1);

      repeat (2 * REF_INTERVAL) @(negedge clk);
      check(ras_falls == accepted, "R10 one row activation per access", ras_falls, accepted);

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule